// File: doc/BRIEF.md
# Two-Pool Round-Robin Channel Arbiter with Post-Packet Lockout

This block decides which of four work channels may use a shared processing engine next. Every channel carries a pool bit that puts it either in the urgent pool or in the background pool. Any eligible urgent request beats every background request. Within a pool, service rotates round-robin, starting just after that pool's most recent winner. A winning channel keeps its grant until the engine strobes the end of one packet. The arbiter then holds a fresh round, and the channel that just finished may take part in it.

Each channel also has a small programmable cool-down value. When a channel finishes a packet, a per-channel counter loads sixteen times that value. The channel stays out of arbitration until the counter has drained back to zero. A value of zero gives no cool-down, so the finishing channel may win the very next round. Urgent channels can use a non-zero value to let background work through between their packets.

Top module: `pool_rr_arbiter`

## Requirements
- R1: `grant_o` is one-hot or all-zero at every cycle. Bit c of `req_i`, `hi_pool_i` and `grant_o` refers to channel c. A newly issued grant goes only to a channel whose request was high in the cycle the round was evaluated.
- R2: A channel with its `hi_pool_i` bit at 1 is urgent and one at 0 is background. When any eligible urgent channel requests, an urgent channel receives the grant.
- R3: A grant stays unchanged, whatever `req_i`, `hi_pool_i` and `recov_val_i` do, until `pkt_done_i` is sampled high while it is held. The grant then drops to zero at the next edge.
- R4: Within a pool, the search for a winner starts at the channel after that pool's last winner and wraps from 3 to 0. A just-served channel that requests again therefore comes last within its pool.
- R5: Channel c's cool-down value is `recov_val_i[4c+3:4c]`. Suppose channel c finishes a packet with value V > 0 and is the only requester. Its next grant then appears at the (16·V+1)-th rising edge after the edge that sampled `pkt_done_i`.
- R6: A non-zero cool-down value keeps the finishing channel out of the round that directly follows its packet, even when it is urgent and the other requesters are background.
- R7: With a cool-down value of zero, the finishing channel can be granted at the first edge after the edge that sampled `pkt_done_i`.
- R8: While the arbiter is idle, a grant is registered at the first edge after a request is presented.
- R9: Reset clears the grant and all cool-down counters, and points both pools so that channel 0 is searched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 4 | Per-channel service request |
| hi_pool_i | input | 4 | Per-channel pool select: 1 urgent, 0 background |
| recov_val_i | input | 16 | Per-channel cool-down value, 4 bits each, channel c at [4c+3:4c] |
| pkt_done_i | input | 1 | Engine strobe marking the end of the granted channel's packet |
| grant_o | output | 4 | Registered one-hot grant |

## Verification
The hardest case to reach from the ports is an urgent channel whose cool-down is non-zero. That channel must lose the round right after its own packet to a background requester, and then win again once its counter drains. The stimulus reaches this case by changing the requests, pools and cool-down values only while a grant is held. This works because a held grant ignores those inputs. The values then take effect in exactly the round that follows the done strobe, and the number of edges until the next grant is measured against 16·V+1.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int POOL_LO   = 0;
  localparam int POOL_HI   = 1;
  localparam int NUM_POOLS = 2;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/arb_recov_timer.sv
module arb_recov_timer #(
  parameter int RECOV_W     = 4,
  parameter int SCALE_SHIFT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [RECOV_W-1:0] value_i,
  output logic               locked_o
);
  localparam int CNT_W = RECOV_W + SCALE_SHIFT;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = {value_i, {SCALE_SHIFT{1'b0}}};
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign locked_o = (cnt_q != '0);
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int cand;
      cand = (int'(last_i) + off) % N;
      if (!any_o && req_i[cand]) begin
        any_o       = 1'b1;
        gnt_o[cand] = 1'b1;
        idx_o       = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/pool_rr_arbiter.sv
module pool_rr_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int RECOV_W     = 4,
  parameter int SCALE_SHIFT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         req_i,
  input  logic [NUM_CH-1:0]         hi_pool_i,
  input  logic [NUM_CH*RECOV_W-1:0] recov_val_i,
  input  logic                      pkt_done_i,
  output logic [NUM_CH-1:0]         grant_o
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              rst_n_core;
  logic [NUM_CH-1:0] grant_q;
  logic [NUM_CH-1:0] grant_d;
  logic              busy;
  logic [NUM_CH-1:0] chan_locked;
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] pool_req [NUM_POOLS];
  logic [NUM_CH-1:0] pool_gnt [NUM_POOLS];
  logic [IDX_W-1:0]  pool_idx [NUM_POOLS];
  logic              pool_any [NUM_POOLS];
  logic              ptr_en   [NUM_POOLS];

  arb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_core)
  );

  assign busy = |grant_q;

  // Per-channel cool-down counters, loaded when the granted packet ends
  for (genvar c = 0; c < NUM_CH; c++) begin : g_timer
    arb_recov_timer #(
      .RECOV_W     (RECOV_W),
      .SCALE_SHIFT (SCALE_SHIFT)
    ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n_core),
      .load_i   (pkt_done_i & grant_q[c]),
      .value_i  (recov_val_i[c*RECOV_W +: RECOV_W]),
      .locked_o (chan_locked[c])
    );
  end

  assign eligible           = req_i & ~chan_locked;
  assign pool_req[POOL_HI]  = eligible & hi_pool_i;
  assign pool_req[POOL_LO]  = eligible & ~hi_pool_i;

  // One rotating pointer and picker per pool
  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    logic [IDX_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n_core) begin
      if (!rst_n_core) begin
        last_q <= IDX_W'(NUM_CH - 1);
      end else if (ptr_en[p]) begin
        last_q <= pool_idx[p];
      end
    end

    arb_rr_pick #(
      .N  (NUM_CH),
      .IW (IDX_W)
    ) u_pick (
      .req_i  (pool_req[p]),
      .last_i (last_q),
      .gnt_o  (pool_gnt[p]),
      .idx_o  (pool_idx[p]),
      .any_o  (pool_any[p])
    );
  end

  always_comb begin
    grant_d          = grant_q;
    ptr_en[POOL_HI]  = 1'b0;
    ptr_en[POOL_LO]  = 1'b0;
    if (busy) begin
      if (pkt_done_i) begin
        grant_d = '0;
      end
    end else if (pool_any[POOL_HI]) begin
      grant_d         = pool_gnt[POOL_HI];
      ptr_en[POOL_HI] = 1'b1;
    end else if (pool_any[POOL_LO]) begin
      grant_d         = pool_gnt[POOL_LO];
      ptr_en[POOL_LO] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_core) begin
    if (!rst_n_core) begin
      grant_q <= '0;
    end else begin
      grant_q <= grant_d;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/arb_sva.sv
module arb_sva #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req_i,
  input logic [NUM_CH-1:0] hi_pool_i,
  input logic              pkt_done_i,
  input logic [NUM_CH-1:0] grant_o,
  input logic [NUM_CH-1:0] chan_locked
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R1

  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && $past(grant_o) == '0) |-> ((grant_o & $past(req_i)) != '0)); // R1

  AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && $past(grant_o) == '0 && (grant_o & $past(hi_pool_i)) == '0)
      |-> ($past(req_i & hi_pool_i & ~chan_locked) == '0)); // R2

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && !pkt_done_i) |=> (grant_o == $past(grant_o))); // R3

  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && pkt_done_i) |=> (grant_o == '0)); // R3

  AST_NO_LOCKED_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0 && $past(grant_o) == '0) |-> ((grant_o & $past(chan_locked)) == '0)); // R6
endmodule

bind pool_rr_arbiter arb_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .hi_pool_i   (hi_pool_i),
  .pkt_done_i  (pkt_done_i),
  .grant_o     (grant_o),
  .chan_locked (chan_locked)
);

// File: tb/sim_pool_rr_arbiter.sv
module sim_pool_rr_arbiter;
  logic        clk;
  logic        rst_n;
  logic [3:0]  req;
  logic [3:0]  hi;
  logic [15:0] recov;
  logic        done;
  logic [3:0]  grant;

  int n_tests;
  int n_fail;
  bit finished;

  // {req, hi_pool, expected grant}; cool-down values all zero
  localparam logic [11:0] VEC [15] = '{
    12'hF01, 12'hF02, 12'hF04, 12'hF08, 12'hF01,
    12'hF88, 12'hFA2, 12'hFA8, 12'h5A4, 12'h501,
    12'h101, 12'h911, 12'h662, 12'h664, 12'hC44
  };

  pool_rr_arbiter u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .hi_pool_i   (hi),
    .recov_val_i (recov),
    .pkt_done_i  (done),
    .grant_o     (grant)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs are already set. End the held packet (if any) and measure the
  // number of edges after the done-sampling edge until the next grant.
  task automatic serve(input logic [3:0] exp_g, input int exp_lat, input string tag);
    bit had;
    int lat;
    had = (grant != 4'b0);
    if (had) done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    lat = had ? 0 : 1;
    while (grant == 4'b0 && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    check(grant == exp_g, {tag, " grant"}, int'(grant), int'(exp_g));
    check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
  endtask

  initial begin
    bit stable;
    logic [3:0] held;
    n_tests = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; req = 4'h0; hi = 4'h0; recov = 16'h0; done = 1'b0;
    repeat (3) @(negedge clk);
    check(grant == 4'b0, "R9 grant in reset", int'(grant), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(grant == 4'b0, "R9 idle after reset", int'(grant), 0);

    // Vector walk: R1 R2 R4 R7 R8
    for (int i = 0; i < 15; i++) begin
      req = VEC[i][11:8];
      hi  = VEC[i][7:4];
      serve(VEC[i][3:0], 1, $sformatf("R2 R4 R7 R8 vec%0d", i));
    end

    // Cool-down of one unit on channel 1 (held: ch2)
    recov = 16'h0010; req = 4'b0010; hi = 4'b0000;
    serve(4'b0010, 1, "R7 ch1 first win");
    serve(4'b0010, 17, "R5 ch1 lockout V=1");

    // Urgent ch1 locked, background ch0 takes the next round
    req = 4'b0011; hi = 4'b0010;
    serve(4'b0001, 1, "R6 locked urgent skipped");

    // Grant held while inputs move
    held = grant; stable = 1'b1;
    for (int k = 0; k < 20; k++) begin
      req = 4'(k); hi = ~4'(k); recov = 16'(k * 37);
      @(negedge clk);
      if (grant != held) stable = 1'b0;
    end
    check(stable, "R3 grant held without done", int'(grant), int'(held));

    req = 4'b0011; hi = 4'b0010; recov = 16'h0020;
    serve(4'b0010, 1, "R2 urgent over background");
    req = 4'b0010;
    serve(4'b0010, 33, "R5 ch1 lockout V=2");

    // Long lockout then reset must clear it
    recov = 16'h00F0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check(grant == 4'b0, "R3 release after done", int'(grant), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(grant == 4'b0, "R9 grant cleared", int'(grant), 0);
    rst_n = 1'b1; req = 4'b0000; recov = 16'h0000; hi = 4'b0000;
    repeat (4) @(negedge clk);
    req = 4'b0011;
    serve(4'b0001, 1, "R9 pointer reset ch0 first");
    req = 4'b0010;
    serve(4'b0010, 1, "R9 counter cleared");

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule